// File: doc/BRIEF.md
# Full-Speed USB Receive Clock and Data Recovery

This block is the receive path that sits between a USB full-speed transceiver and the packet layer. It runs on a sampling clock four times the 12 Mbit/s line rate (48 MHz). Its inputs are the two single-ended line levels, already synchronised to that clock, and the differential receiver output. It sorts each sample into J, K or SE0 and removes short glitches. It recovers a bit strobe that re-centres on every line transition and turns the NRZI line code back into binary data. It then drops the zeros the transmitter inserted after long runs of ones.

Downstream logic sees a serial stream of decoded bits, each qualified by a one-cycle valid pulse. A packet-active level frames the stream. A one-cycle end-of-packet pulse marks a correctly terminated packet, and a bit-stuff error flag marks a packet as bad. The decoded stream starts with the synchronisation pattern, so the packet layer can check it and strip it. Everything in the block is a single stream path. It has no storage other than a handful of state registers.

Top module: `usbrx_cdr`

## Requirements
- R1: While reset is asserted, and right after it, rx_valid, rx_eop, pkt_active and stuff_err are all 0.
- R2: A sample is SE0 when line_dp and line_dm are both 0, whatever line_diff is. Otherwise it is J when line_diff is 1 and K when line_diff is 0, even if both single-ended inputs are 1.
- R3: A line state that lasts fewer than FILT_LEN (default 2) consecutive sampling ticks is ignored, and the decoded stream is unchanged.
- R4: Exactly one bit is recovered for each bit time of OVS (default 4) ticks. The bit is sampled at the middle tick, and the phase is re-aligned on every filtered transition. Bit cells of 3 or 5 ticks therefore decode correctly.
- R5: pkt_active rises on the first recovered J-to-K change after a J sample. In that same cycle rx_valid delivers the first decoded bit, which is 0.
- R6: Each recovered J or K sample in a packet decodes to 1 if it equals the previous J/K sample, and to 0 if it differs.
- R7: After six consecutive decoded 1s, a following 0 is a stuffed bit. It is discarded: no rx_valid is given for it, and the run count restarts.
- R8: A 1 in the stuffed-bit position is not delivered and sets stuff_err. stuff_err stays 1 until the next packet start or reset.
- R9: Two or more SE0 samples followed by a J sample give a one-cycle rx_eop pulse, and pkt_active falls in that same cycle.
- R10: While the line idles in J, no rx_valid is produced and pkt_active stays 0.
- R11: rx_valid is only given while pkt_active is 1, and SE0 samples produce no data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, four ticks per bit |
| rst_n | input | 1 | Synchronous active-low reset |
| line_dp | input | 1 | Synchronised single-ended level of the positive data line |
| line_dm | input | 1 | Synchronised single-ended level of the negative data line |
| line_diff | input | 1 | Synchronised differential receiver output, 1 for J |
| rx_bit | output | 1 | Decoded data bit, meaningful while rx_valid is 1 |
| rx_valid | output | 1 | One-cycle strobe for each delivered bit |
| pkt_active | output | 1 | High from packet start until end of packet |
| rx_eop | output | 1 | One-cycle pulse on a correctly terminated packet |
| stuff_err | output | 1 | Bit-stuff violation seen in the current or last packet |

## Verification
A phase counter that slips or misses a re-alignment shows up at the ports within one or two bit times. The stream gains or loses a bit, and this shows as a wrong count of rx_valid pulses for the packet. A wrong run-of-ones count shows within seven bits, either as a delivered stuffed zero or as a spurious stuff_err. A stale previous-level register flips every decoded bit after the first wrong one. A broken SE0 counter shows at packet end as a missing rx_eop pulse or a pkt_active that never falls. The bench sends packets with stuffing, stuffing violations, glitches and cell-length jitter, and compares each decoded stream bit for bit with the one it encoded itself.

// File: rtl/usbrx_pkg.sv
// Shared types for the full-speed receive recovery path.
package usbrx_pkg;
    // Recovered line state after classification of the three line inputs.
    typedef enum logic [1:0] {
        LS_SE0 = 2'd0,
        LS_J   = 2'd1,
        LS_K   = 2'd2
    } line_t;
endpackage

// File: rtl/usbrx_glitch_filter.sv
// Classifies the synchronised line inputs into J, K or SE0, and passes a new
// state on only after it has been seen on FILT_LEN consecutive ticks.
// Assumes: inputs already synchronised to clk; FILT_LEN >= 2.
module usbrx_glitch_filter
    import usbrx_pkg::*;
#(
    parameter int FILT_LEN = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dp_i,
    input  logic  dm_i,
    input  logic  diff_i,
    output line_t state_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    line_t          raw;
    line_t          cand_q;
    line_t          filt_q;
    logic [CW-1:0]  cnt_q;

    // Classify the raw inputs: both single-ended lows is SE0, else follow diff.
    always_comb begin
        if (!dp_i && !dm_i) raw = LS_SE0;
        else if (diff_i)    raw = LS_J;
        else                raw = LS_K;
    end

    // Track a candidate state and accept it after FILT_LEN matching ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= LS_J;
            filt_q <= LS_J;
            cnt_q  <= CW'(FILT_LEN);
        end else if (raw != cand_q) begin
            cand_q <= raw;
            cnt_q  <= CW'(1);
        end else begin
            if (cnt_q < CW'(FILT_LEN)) cnt_q <= cnt_q + CW'(1);
            if (cnt_q >= CW'(FILT_LEN - 1)) filt_q <= cand_q;
        end
    end

    assign state_o = filt_q;

    // R3
    filt_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> ($past(raw) == filt_q));
endmodule

// File: rtl/usbrx_dpll.sv
// Recovers a bit strobe from the filtered line state. The phase counter
// restarts on every transition, and a strobe fires at the middle tick of
// each OVS-tick bit cell, never in the cycle where a transition is seen.
// Assumes: OVS is a power of two, at least 4.
module usbrx_dpll
    import usbrx_pkg::*;
#(
    parameter int OVS = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  line_t state_i,
    output logic  strobe_o,
    output line_t sample_o
);
    localparam int            PW  = $clog2(OVS);
    localparam logic [PW-1:0] MID = PW'(OVS / 2);
    localparam logic [PW-1:0] TOP = PW'(OVS - 1);

    line_t          prev_q;
    logic [PW-1:0]  phase_q;
    logic           edge_w;

    assign edge_w = (state_i != prev_q);

    // Remember the last state and advance or restart the phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= LS_J;
            phase_q <= '0;
        end else begin
            prev_q <= state_i;
            if (edge_w)              phase_q <= PW'(1);
            else if (phase_q == TOP) phase_q <= '0;
            else                     phase_q <= phase_q + PW'(1);
        end
    end

    assign strobe_o = (phase_q == MID) && !edge_w;
    assign sample_o = state_i;

    // R4
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (!$past(strobe_o) && !$past(strobe_o, 2)));
endmodule

// File: rtl/usbrx_nrzi_unstuff.sv
// Per recovered sample: detects packet start, decodes NRZI, drops stuffed
// zeros, flags stuffing violations and detects SE0-based end of packet.
// Assumes: sample_i is valid when strobe_i is 1; one strobe per bit time.
module usbrx_nrzi_unstuff
    import usbrx_pkg::*;
#(
    parameter int STUFF_RUN   = 6,
    parameter int EOP_SE0_MIN = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  strobe_i,
    input  line_t sample_i,
    output logic  bit_o,
    output logic  valid_o,
    output logic  active_o,
    output logic  eop_o,
    output logic  err_o
);
    localparam int OW = $clog2(STUFF_RUN + 1);
    localparam int SW = $clog2(EOP_SE0_MIN + 1);

    logic           active_q;
    logic           bit_q;
    logic           valid_q;
    logic           eop_q;
    logic           err_q;
    line_t          last_q;
    line_t          prev_s_q;
    logic [OW-1:0]  ones_q;
    logic [SW-1:0]  se0_q;
    logic           same_w;

    assign same_w = (sample_i == last_q);

    // Advance the packet state machine once per recovered bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            bit_q    <= 1'b0;
            valid_q  <= 1'b0;
            eop_q    <= 1'b0;
            err_q    <= 1'b0;
            last_q   <= LS_J;
            prev_s_q <= LS_SE0;
            ones_q   <= '0;
            se0_q    <= '0;
        end else begin
            valid_q <= 1'b0;
            eop_q   <= 1'b0;
            if (strobe_i) begin
                prev_s_q <= sample_i;
                if (!active_q) begin
                    if (prev_s_q == LS_J && sample_i == LS_K) begin
                        active_q <= 1'b1;
                        err_q    <= 1'b0;
                        valid_q  <= 1'b1;
                        bit_q    <= 1'b0;
                        ones_q   <= '0;
                        se0_q    <= '0;
                        last_q   <= LS_K;
                    end
                end else if (sample_i == LS_SE0) begin
                    if (se0_q < SW'(EOP_SE0_MIN)) se0_q <= se0_q + SW'(1);
                end else if (se0_q >= SW'(EOP_SE0_MIN)) begin
                    active_q <= 1'b0;
                    eop_q    <= (sample_i == LS_J);
                    se0_q    <= '0;
                end else begin
                    se0_q  <= '0;
                    last_q <= sample_i;
                    if (ones_q == OW'(STUFF_RUN)) begin
                        ones_q <= '0;
                        if (same_w) err_q <= 1'b1;
                    end else begin
                        valid_q <= 1'b1;
                        bit_q   <= same_w;
                        ones_q  <= same_w ? ones_q + OW'(1) : '0;
                    end
                end
            end
        end
    end

    assign bit_o    = bit_q;
    assign valid_o  = valid_q;
    assign active_o = active_q;
    assign eop_o    = eop_q;
    assign err_o    = err_q;

    // R11
    valid_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> active_q);
    // R9
    eop_ends_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eop_q |-> (!active_q && $past(active_q)));
    // R8
    err_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> active_q);
    // R7
    ones_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= OW'(STUFF_RUN));
    // R5
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> (valid_q && !bit_q));
endmodule

// File: rtl/usbrx_cdr.sv
// Top of the full-speed receive recovery path: glitch filter, bit-strobe
// recovery, then NRZI decode with unstuffing and end-of-packet detection.
// Assumes: clk is OVS times the bit rate; line inputs are synchronised.
module usbrx_cdr
    import usbrx_pkg::*;
#(
    parameter int OVS         = 4,
    parameter int FILT_LEN    = 2,
    parameter int STUFF_RUN   = 6,
    parameter int EOP_SE0_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_dp,
    input  logic line_dm,
    input  logic line_diff,
    output logic rx_bit,
    output logic rx_valid,
    output logic pkt_active,
    output logic rx_eop,
    output logic stuff_err
);
    line_t filt_state;
    line_t sample;
    logic  strobe;

    usbrx_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .dp_i    (line_dp),
        .dm_i    (line_dm),
        .diff_i  (line_diff),
        .state_o (filt_state)
    );

    usbrx_dpll #(.OVS(OVS)) u_dpll (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_i  (filt_state),
        .strobe_o (strobe),
        .sample_o (sample)
    );

    usbrx_nrzi_unstuff #(
        .STUFF_RUN   (STUFF_RUN),
        .EOP_SE0_MIN (EOP_SE0_MIN)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe),
        .sample_i (sample),
        .bit_o    (rx_bit),
        .valid_o  (rx_valid),
        .active_o (pkt_active),
        .eop_o    (rx_eop),
        .err_o    (stuff_err)
    );
endmodule

// File: tb/usbrx_cdr_tb.sv
// Self-checking bench: table-driven packets, then directed reset and
// classification cases. Line states: 0 = SE0, 1 = J, 2 = K.
module usbrx_cdr_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_dp = 1'b1, line_dm = 1'b0, line_diff = 1'b1;
    logic rx_bit, rx_valid, pkt_active, rx_eop, stuff_err;

    always #2.5 clk = ~clk;

    usbrx_cdr u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_dp    (line_dp),
        .line_dm    (line_dm),
        .line_diff  (line_diff),
        .rx_bit     (rx_bit),
        .rx_valid   (rx_valid),
        .pkt_active (pkt_active),
        .rx_eop     (rx_eop),
        .stuff_err  (stuff_err)
    );

    // Vector: {jitter, glitch, bad_stuff, len[5:0], payload[31:0] LSB first}
    localparam int NVEC = 6;
    localparam logic [40:0] VEC [0:NVEC-1] = '{
        {3'b000, 6'd8,  32'h0000_00A5},
        {3'b000, 6'd16, 32'h0000_FFFF},
        {3'b000, 6'd12, 32'h0000_0000},
        {3'b001, 6'd16, 32'h0000_FFFF},
        {3'b100, 6'd20, 32'h000F_3C7F},
        {3'b010, 6'd24, 32'h007E_81FF}
    };

    int tests = 0, fails = 0;
    int got_n = 0, eop_cnt = 0, stray_valid = 0;
    bit saw_act = 0, collect = 0, done = 0;
    logic got_b [0:255];
    logic exp_b [0:255];
    logic tx_b  [0:255];

    // Collect decoded bits and events away from the active edge.
    always @(negedge clk) begin
        if (collect) begin
            if (rx_valid) begin
                if (got_n < 256) got_b[got_n] = rx_bit;
                got_n++;
                if (!pkt_active) stray_valid++;
            end
            if (rx_eop) eop_cnt++;
            if (pkt_active) saw_act = 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_raw(input logic p, input logic m, input logic d, input int n);
        line_dp = p; line_dm = m; line_diff = d;
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input int st, input int n);
        case (st)
            0:       drive_raw(1'b0, 1'b0, 1'b0, n);
            1:       drive_raw(1'b1, 1'b0, 1'b1, n);
            default: drive_raw(1'b0, 1'b1, 1'b0, n);
        endcase
    endtask

    task automatic run_vec(input logic [40:0] e);
        int    len = int'(e[37:32]);
        bit    jit = e[40], gl = e[39], bad = e[38];
        int    n_exp = 0, n_tx = 0, ones = 0, lvl = 1, mism = 0, nt;
        logic  b;
        string tag;
        for (int i = 0; i < 8 + len; i++) begin
            b = (i < 8) ? (i == 7) : e[i-8];
            exp_b[n_exp] = b; n_exp++;
            tx_b[n_tx] = b; n_tx++;
            ones = b ? ones + 1 : 0;
            if (ones == 6) begin
                tx_b[n_tx] = bad; n_tx++;
                ones = 0;
            end
        end
        got_n = 0; eop_cnt = 0; saw_act = 0; stray_valid = 0; collect = 1;
        drive(1, 16);
        for (int i = 0; i < n_tx; i++) begin
            if (!tx_b[i]) lvl = (lvl == 1) ? 2 : 1;
            nt = jit ? ((i % 2 == 0) ? 5 : 3) : 4;
            if (gl && tx_b[i]) begin
                drive(lvl, 2);
                drive((lvl == 1) ? 2 : 1, 1);
                drive(lvl, nt - 3);
            end else begin
                drive(lvl, nt);
            end
        end
        drive(0, 8);
        drive(1, 20);
        collect = 0;
        if (gl)       tag = "R3 glitch-filtered stream";
        else if (jit) tag = "R4 jittered-cell stream";
        else if (bad) tag = "R8 stream with stuffing violation";
        else          tag = "R6 R7 decoded stream";
        for (int i = 0; i < n_exp && i < got_n; i++)
            if (got_b[i] !== exp_b[i]) mism++;
        check(got_n == n_exp, {tag, " bit count"}, got_n, n_exp);
        check(mism == 0, {tag, " mismatching bits"}, mism, 0);
        check(eop_cnt == 1, "R9 one EOP pulse per packet", eop_cnt, 1);
        check(pkt_active == 1'b0, "R9 packet-active cleared after EOP", int'(pkt_active), 0);
        check(saw_act, "R5 packet-active raised during packet", int'(saw_act), 1);
        check(stuff_err == bad, "R8 stuff error flag", int'(stuff_err), int'(bad));
        check(stray_valid == 0, "R11 no valid outside packet", stray_valid, 0);
    endtask

    initial begin
        drive(1, 6);
        check(!rx_valid && !rx_eop && !pkt_active && !stuff_err, "R1 outputs during reset",
              int'({rx_valid, rx_eop, pkt_active, stuff_err}), 0);
        rst_n = 1'b1;
        drive(1, 2);
        check(!rx_valid && !rx_eop && !pkt_active && !stuff_err, "R1 outputs after reset",
              int'({rx_valid, rx_eop, pkt_active, stuff_err}), 0);

        for (int v = 0; v < NVEC; v++) run_vec(VEC[v]);

        // R10: long J idle gives nothing.
        got_n = 0; collect = 1;
        drive(1, 60);
        check(got_n == 0, "R10 no bits while idle", got_n, 0);
        check(pkt_active == 1'b0, "R10 no packet while idle", int'(pkt_active), 0);

        // R2: SE0 wins over diff=1, so SE0 then K is not a start.
        drive_raw(1'b0, 1'b0, 1'b1, 8);
        drive(2, 12);
        check(pkt_active == 1'b0 && got_n == 0, "R2 SE0 with diff high is SE0",
              int'(pkt_active), 0);
        // R2: both single-ended high with diff low is K, so J then it starts a packet.
        drive(1, 12);
        drive_raw(1'b1, 1'b1, 1'b0, 12);
        check(pkt_active == 1'b1, "R2 diff low decides K", int'(pkt_active), 1);
        check(got_n >= 1 && got_b[0] == 1'b0, "R5 first decoded bit is 0",
              int'(got_b[0]), 0);
        collect = 0;

        // R1: reset in mid-packet clears the packet state.
        drive(1, 1);
        rst_n = 1'b0;
        drive(1, 3);
        check(!pkt_active && !rx_valid && !stuff_err, "R1 reset mid-packet",
              int'(pkt_active), 0);
        rst_n = 1'b1;
        drive(1, 16);
        run_vec(VEC[0]);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule